// File: doc/BRIEF.md
# Event Flag Interrupt Controller

This block gathers single-cycle event pulses from timekeeping logic (periodic tick, alarm match, update-ended) into sticky flags. Each flag has its own enable bit, held in a small enable register that is loaded through a write strobe. When any flag is pending together with its enable, the block pulls an active-low open-drain interrupt request low. The pin is modelled as an output-enable plus a constant-low level, so it is never driven high.

Software reads a status byte to find out which events occurred. During the read cycle the byte shows the flags as they stood before the read. The clock edge that ends the read clears the flags and releases the interrupt. An event that arrives in the same cycle as the read survives the clear. Reset empties the flags and the enables and releases the pin.

A two-state machine tracks the pin. The states are `S_QUIET` (pin released) and `S_REQ` (pin driven low). There are two transitions:
- *raise* (`S_QUIET`→`S_REQ`) fires when the next flag and enable values hold an enabled pending event.
- *release* (`S_REQ`→`S_QUIET`) fires when they hold none, either after a clearing read or after the enable is withdrawn.

Top module: `evt_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `irq_oe` is 0 and `stat_q` is 0x00. Reset clears every flag and every enable bit.
- R2: An `evt_pulse[i]` high at a clock edge sets flag i. Flag i appears in `stat_q` at bit 4+i: update-ended i=0 is bit 4, alarm i=1 is bit 5, periodic i=2 is bit 6. The flag stays set on later cycles until a status read clears it.
- R3: `irq_oe` goes to 1 in the cycle after a flag and its enable are both set, with no `stat_rd` or `en_wr` activity needed. `irq_lvl` is always 0, so the pin is only ever driven low or released.
- R4: A flag whose enable bit is 0 shows in `stat_q` but neither drives `irq_oe` nor sets `stat_q[7]`.
- R5: `stat_q[7]` is the OR of all pending flags whose enable is set, and it equals `irq_oe`. `stat_q[3:0]` always reads 0.
- R6: While `stat_rd` is high, `stat_q` shows the pre-clear flags. After that edge, every flag without a new pulse reads 0, and `irq_oe` is 0 unless a new enabled event arrived.
- R7: An `evt_pulse[i]` high in the same cycle as `stat_rd` leaves flag i set after the read.
- R8: `en_wr` loads `en_wdata` into the enable register; bit i enables flag i. Enabling an already pending flag raises `irq_oe` in the next cycle, and clearing its enable releases `irq_oe` in the next cycle without touching the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | N_EVT | One-cycle event pulses (0 update-ended, 1 alarm, 2 periodic) |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | N_EVT | Enable bits to load |
| stat_rd | input | 1 | Status read strobe; clears flags at the end of the cycle |
| stat_q | output | STAT_W | Status byte: bit 7 summary, bits 4+i flags, rest 0 |
| irq_oe | output | 1 | Interrupt pin output enable (1 = pull low) |
| irq_lvl | output | 1 | Interrupt pin level, tied to 0 |

## Verification
The bench builds the block with its defaults, three events and an eight-bit status byte. With those values every real source has its own flag position, several sources can pulse together, and the zero bits below the flag field can be checked directly. The directed scenarios cover three things. The first is the enable/flag combinations that decide the two transitions. The second is the collision of a pulse with a clearing read. The third is that enable changes raise or drop the pin while leaving the flags untouched.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    typedef enum logic {
        S_QUIET = 1'b0,
        S_REQ   = 1'b1
    } irq_state_t;
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
    parameter int N_EVT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt_pulse,
    input  logic             clr,
    output logic [N_EVT-1:0] flags_q,
    output logic [N_EVT-1:0] flags_nxt
);
    // One sticky bit per source; a fresh pulse wins over the clear.
    for (genvar i = 0; i < N_EVT; i++) begin : g_flag
        assign flags_nxt[i] = evt_pulse[i] | (flags_q[i] & ~clr);

        always_ff @(posedge clk) begin
            if (!rst_n) flags_q[i] <= 1'b0;
            else        flags_q[i] <= flags_nxt[i];
        end
    end
endmodule

// File: rtl/evt_en_reg.sv
module evt_en_reg #(
    parameter int N_EVT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic [N_EVT-1:0] en_wdata,
    output logic [N_EVT-1:0] en_q,
    output logic [N_EVT-1:0] en_nxt
);
    assign en_nxt = en_wr ? en_wdata : en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_nxt;
    end
endmodule

// File: rtl/evt_irq_fsm.sv
module evt_irq_fsm
    import evt_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_nxt,
    output logic irq_oe
);
    irq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_QUIET: if (pend_nxt)  state_d = S_REQ;   // raise
            S_REQ:   if (!pend_nxt) state_d = S_QUIET; // release
            default: state_d = S_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_oe = 1'b0;
        unique case (state_q)
            S_QUIET: irq_oe = 1'b0;
            S_REQ:   irq_oe = 1'b1;
            default: irq_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
    parameter int N_EVT  = 3,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EVT-1:0]  evt_pulse,
    input  logic              en_wr,
    input  logic [N_EVT-1:0]  en_wdata,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] stat_q,
    output logic              irq_oe,
    output logic              irq_lvl
);
    // Flag field sits just below the summary bit; needs N_EVT < STAT_W-1.
    localparam int FLD_LO = STAT_W - 1 - N_EVT;

    logic [N_EVT-1:0] flags_q, flags_nxt, en_q, en_nxt;

    evt_flag_bank #(.N_EVT(N_EVT)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .clr       (stat_rd),
        .flags_q   (flags_q),
        .flags_nxt (flags_nxt)
    );

    evt_en_reg #(.N_EVT(N_EVT)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .en_q     (en_q),
        .en_nxt   (en_nxt)
    );

    evt_irq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_nxt (|(flags_nxt & en_nxt)),
        .irq_oe   (irq_oe)
    );

    always_comb begin
        stat_q = '0;
        stat_q[STAT_W-1] = |(flags_q & en_q);
        for (int i = 0; i < N_EVT; i++) stat_q[FLD_LO+i] = flags_q[i];
    end

    assign irq_lvl = 1'b0;
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
    parameter int N_EVT  = 3,
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_EVT-1:0]  evt_pulse,
    input logic              stat_rd,
    input logic [STAT_W-1:0] stat_q,
    input logic              irq_oe
);
    localparam int FLD_LO = STAT_W - 1 - N_EVT;

    // R1: state seen right after reset is empty
    p_rst_empty_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!irq_oe && stat_q == '0));

    // R5: pin and summary bit agree
    p_pin_summary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe == stat_q[STAT_W-1]);

    // R6: a read with no new pulse empties everything
    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && evt_pulse == '0) |=> (stat_q == '0 && !irq_oe));

    for (genvar i = 0; i < N_EVT; i++) begin : g_evt
        // R2: pulse sets flag
        p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            evt_pulse[i] |=> stat_q[FLD_LO+i]);
        // R2: flag is sticky without a read
        p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!stat_rd && stat_q[FLD_LO+i]) |=> stat_q[FLD_LO+i]);
        // R7: pulse during read survives
        p_collide_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_rd && evt_pulse[i]) |=> stat_q[FLD_LO+i]);
    end
endmodule

bind evt_irq_ctrl evt_irq_chk #(.N_EVT(N_EVT), .STAT_W(STAT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .stat_rd   (stat_rd),
    .stat_q    (stat_q),
    .irq_oe    (irq_oe)
);

// File: tb/evt_irq_ctrl_tb.sv
module evt_irq_ctrl_tb;
    localparam int N = 3;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt_pulse = '0;
    logic         en_wr = 1'b0;
    logic [N-1:0] en_wdata = '0;
    logic         stat_rd = 1'b0;
    logic [W-1:0] stat_q;
    logic         irq_oe, irq_lvl;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    evt_irq_ctrl #(.N_EVT(N), .STAT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .en_wr(en_wr),
        .en_wdata(en_wdata), .stat_rd(stat_rd), .stat_q(stat_q),
        .irq_oe(irq_oe), .irq_lvl(irq_lvl)
    );

    function automatic logic [7:0] exp_stat(logic [2:0] f, logic [2:0] e);
        return {|(f & e), f, 4'b0000};
    endfunction

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse(logic [2:0] e);
        evt_pulse = e; step(); evt_pulse = '0;
    endtask

    task automatic wr_en(logic [2:0] e);
        en_wr = 1'b1; en_wdata = e; step(); en_wr = 1'b0;
    endtask

    task automatic rd_clear();
        stat_rd = 1'b1; step(); stat_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step(); step();
        chk("R1 oe in reset", {7'd0, irq_oe}, 8'h00);
        chk("R1 stat in reset", stat_q, 8'h00);
        rst_n = 1'b1; step();
        chk("R1 stat after reset", stat_q, 8'h00);
        chk("R1 oe after reset", {7'd0, irq_oe}, 8'h00);
    endtask

    task automatic t_masked();
        pulse(3'b010);
        chk("R4 masked flag", stat_q, exp_stat(3'b010, 3'b000));
        chk("R4 masked oe", {7'd0, irq_oe}, 8'h00);
        step(); step();
        chk("R2 sticky", stat_q, exp_stat(3'b010, 3'b000));
        rd_clear();
        chk("R6 cleared", stat_q, 8'h00);
    endtask

    task automatic t_raise();
        wr_en(3'b101);
        chk("R3 idle oe", {7'd0, irq_oe}, 8'h00);
        pulse(3'b001);
        chk("R3 raise oe", {7'd0, irq_oe}, 8'h01);
        chk("R5 status", stat_q, exp_stat(3'b001, 3'b101));
        chk("R3 lvl", {7'd0, irq_lvl}, 8'h00);
        pulse(3'b110);
        chk("R2 multi", stat_q, exp_stat(3'b111, 3'b101));
        // read: pre-clear value during the read cycle
        stat_rd = 1'b1; #1;
        chk("R6 pre-clear", stat_q, exp_stat(3'b111, 3'b101));
        step(); stat_rd = 1'b0;
        chk("R6 post-clear", stat_q, 8'h00);
        chk("R6 oe released", {7'd0, irq_oe}, 8'h00);
    endtask

    task automatic t_collide();
        pulse(3'b001);
        stat_rd = 1'b1; evt_pulse = 3'b100; step();
        stat_rd = 1'b0; evt_pulse = '0;
        chk("R7 kept", stat_q, exp_stat(3'b100, 3'b101));
        chk("R7 oe", {7'd0, irq_oe}, 8'h01);
        rd_clear();
        chk("R6 clear2", stat_q, 8'h00);
    endtask

    task automatic t_enable_change();
        wr_en(3'b000);
        pulse(3'b010);
        chk("R4 oe", {7'd0, irq_oe}, 8'h00);
        wr_en(3'b010);
        chk("R8 late enable oe", {7'd0, irq_oe}, 8'h01);
        chk("R8 late enable stat", stat_q, exp_stat(3'b010, 3'b010));
        wr_en(3'b101);
        chk("R8 disable oe", {7'd0, irq_oe}, 8'h00);
        chk("R8 flag kept", stat_q, exp_stat(3'b010, 3'b101));
    endtask

    task automatic t_reset_clears();
        wr_en(3'b111);
        pulse(3'b111);
        chk("R3 all", stat_q, exp_stat(3'b111, 3'b111));
        do_reset();
        pulse(3'b001);
        chk("R1 enables cleared", stat_q, exp_stat(3'b001, 3'b000));
        chk("R1 oe stays off", {7'd0, irq_oe}, 8'h00);
        rd_clear();
    endtask

    initial begin
        fork
            begin
                step();
                do_reset();
                t_masked();
                t_raise();
                t_collide();
                t_enable_change();
                t_reset_clears();
            end
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule